// File: doc/BRIEF.md
# Four-Channel Prescaled Tick Timer Bank

The block holds four independent 32-bit up-counters. All four advance on a common reference tick that an 8-bit prescaler derives from the system clock. With a 25 MHz clock and the default reload value, the tick arrives once per microsecond. The prescaler counts up from a programmable reload value and wraps at 256, so it divides the clock by 256 minus the reload value.

Each timer has three registers: a counter, a compare value and a control word. A match occurs on a tick when the timer is enabled and its counter equals its compare value. A match always sets the timer's status flag. If clear-on-compare is selected, the match also sends the counter back to zero. When the timer's interrupt is enabled, each match also advances a 4-bit event tally. Each timer drives its own interrupt line.

Software reaches every register through a single-cycle write strobe and a combinational read path.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset the prescaler reload reads 0xE7, every timer's control, compare and counter read 0, and all interrupt lines are low.
- R2: The prescaler divides the clock by 256 minus its reload value. It produces one tick per period, and each tick lasts one clock cycle. A new reload value takes effect at the next wrap.
- R3: Control bit 0 enables counting. While it is set, the counter increments by one on every tick. While it is clear, the counter holds its value.
- R4: Control bit 1 selects clear-on-compare. While it is set, a match returns the counter to 0. While it is clear, the counter moves on past the compare value.
- R5: A register write to the counter loads the written value in that cycle, and this write takes priority over a tick.
- R6: Control bits 7:4 form an event tally. It advances by one on each match that occurs while bit 8 is set, and it wraps from 15 to 0. Writing 1 to bit 2 clears the tally; if a match occurs in the same cycle, the clear wins. Bit 2 reads as 0.
- R7: Control bit 10 is the status flag. Every match sets it, whether or not bit 8 is set. Writing 1 to bit 9 clears it; if a match occurs in the same cycle, the set wins. Bit 9 reads as 0.
- R8: Each interrupt output is high exactly when its timer's status flag (bit 10) and interrupt enable (bit 8) are both set.
- R9: Control bits 31:11 and bit 3 always read as 0, whatever value is written to them.
- R10: Address map:
  - The prescaler reload is at 0x00.
  - Timer n, for n from 1 to 4, has its control word at 0x10·n, its compare value at 0x10·n+4 and its counter at 0x10·n+8.
  - Any other address reads 0, and writes to it change nothing.
- R11: A timer's registers and interrupt line are unaffected by any activity on another timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (nominally 25 MHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register byte address |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 4 | Interrupt line per timer, bit i for timer i+1 |

## Verification
The assertions assume two things about the inputs. First, a write strobe lasts exactly one cycle. Second, the address is stable during that cycle. This means that "written value" and "cleared in the same cycle" each refer to a single clock edge. The stimulus raises the strobe for one cycle from a falling edge and changes the address only while the strobe is low. Reads are made only between writes. Long timing windows are measured as counter differences over a known number of edges, so the results do not depend on the prescaler phase.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int TT_DW  = 32;
  localparam int TT_OVW = 4;

  localparam int B_ENC    = 0;
  localparam int B_COC    = 1;
  localparam int B_COVF   = 2;
  localparam int B_OVF_LO = 4;
  localparam int B_ENINT  = 8;
  localparam int B_CINT   = 9;
  localparam int B_INTS   = 10;

  localparam logic [3:0] SUB_CTRL = 4'h0;
  localparam logic [3:0] SUB_CMP  = 4'h4;
  localparam logic [3:0] SUB_CNT  = 4'h8;

  typedef struct packed {
    logic enint;
    logic coc;
    logic enc;
  } tt_cfg_t;

  // next counter value from tick, configuration and match
  function automatic logic [TT_DW-1:0] cnt_next(
    input logic [TT_DW-1:0] cnt, input logic tick,
    input tt_cfg_t cfg, input logic match);
    if (match && cfg.coc) return '0;
    if (tick && cfg.enc)  return cnt + 1'b1;
    return cnt;
  endfunction

  // control word as seen by a reader
  function automatic logic [TT_DW-1:0] ctrl_word(
    input tt_cfg_t cfg, input logic [TT_OVW-1:0] ovf, input logic ints);
    logic [TT_DW-1:0] w;
    w = '0;
    w[B_ENC]   = cfg.enc;
    w[B_COC]   = cfg.coc;
    w[B_OVF_LO +: TT_OVW] = ovf;
    w[B_ENINT] = cfg.enint;
    w[B_INTS]  = ints;
    return w;
  endfunction
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int PW = 8,
  parameter logic [PW-1:0] RESET_RELOAD = 8'hE7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload_we,
  input  logic [PW-1:0] reload_wdata,
  output logic [PW-1:0] reload_o,
  output logic          tick_o
);
  logic [PW-1:0] reload_q, cnt_q;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] c, input logic [PW-1:0] r);
    return (&c) ? r : c + 1'b1;
  endfunction

  assign tick_o   = &cnt_q;
  assign reload_o = reload_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= RESET_RELOAD;
      cnt_q    <= RESET_RELOAD;
    end else begin
      if (reload_we) reload_q <= reload_wdata;
      cnt_q <= step(cnt_q, reload_q);
    end
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (!tick_o || $past(reload_q) == '1)); // R2
endmodule

// File: rtl/tt_decode.sv
module tt_decode #(
  parameter int AW = 8,
  parameter int NT = 4
) (
  input  logic          we,
  input  logic [AW-1:0] addr,
  output logic          presc_we,
  output logic [NT-1:0] ctrl_we,
  output logic [NT-1:0] cmp_we,
  output logic [NT-1:0] cnt_we
);
  import tick_timer_pkg::*;
  localparam int IW = AW - 4;

  logic [IW-1:0] idx;
  logic [3:0]    sub;
  assign idx = addr[AW-1:4];
  assign sub = addr[3:0];
  assign presc_we = we && (addr == '0);

  for (genvar g = 0; g < NT; g++) begin : g_dec
    localparam logic [IW-1:0] MY_IDX = IW'(g + 1);
    assign ctrl_we[g] = we && (idx == MY_IDX) && (sub == SUB_CTRL);
    assign cmp_we[g]  = we && (idx == MY_IDX) && (sub == SUB_CMP);
    assign cnt_we[g]  = we && (idx == MY_IDX) && (sub == SUB_CNT);
  end
endmodule

// File: rtl/tt_channel.sv
module tt_channel
  import tick_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             ctrl_we,
  input  logic             cmp_we,
  input  logic             cnt_we,
  input  logic [TT_DW-1:0] wdata,
  output logic [TT_DW-1:0] cnt_o,
  output logic [TT_DW-1:0] cmp_o,
  output logic [TT_DW-1:0] ctrl_o,
  output logic             irq_o,
  output logic             match_o
);
  tt_cfg_t           cfg_q;
  logic [TT_DW-1:0]  cnt_q, cmp_q;
  logic [TT_OVW-1:0] ovf_q;
  logic              ints_q;

  // named events
  logic match, covf_hit, cint_hit, ovf_step;
  assign match    = tick_i && cfg_q.enc && (cnt_q == cmp_q);
  assign covf_hit = ctrl_we && wdata[B_COVF];
  assign cint_hit = ctrl_we && wdata[B_CINT];
  assign ovf_step = match && cfg_q.enint;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      cnt_q  <= '0;
      cmp_q  <= '0;
      ovf_q  <= '0;
      ints_q <= 1'b0;
    end else begin
      if (ctrl_we) cfg_q <= '{enint: wdata[B_ENINT], coc: wdata[B_COC], enc: wdata[B_ENC]};
      if (cmp_we)  cmp_q <= wdata;
      if (cnt_we)  cnt_q <= wdata;
      else         cnt_q <= cnt_next(cnt_q, tick_i, cfg_q, match);
      if (covf_hit)      ovf_q <= '0;
      else if (ovf_step) ovf_q <= ovf_q + 1'b1;
      if (match)         ints_q <= 1'b1;
      else if (cint_hit) ints_q <= 1'b0;
    end
  end

  assign cnt_o   = cnt_q;
  assign cmp_o   = cmp_q;
  assign ctrl_o  = ctrl_word(cfg_q, ovf_q, ints_q);
  assign irq_o   = ints_q & cfg_q.enint;
  assign match_o = match;

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.enc && !cnt_we) |=> cnt_q == $past(cnt_q)); // R3
  AST_COC_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (match && cfg_q.coc && !cnt_we) |=> cnt_q == '0); // R4
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> cnt_q == $past(wdata)); // R5
  AST_OVF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!covf_hit && !ovf_step) |=> ovf_q == $past(ovf_q)); // R6
  AST_COVF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    covf_hit |=> ovf_q == '0); // R6
  AST_MATCH_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> ints_q); // R7
  AST_CINT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cint_hit && !match) |=> !ints_q); // R7
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tick_timer_pkg::*;
#(
  parameter int NUM_TIMERS = 4,
  parameter int AW = 8,
  parameter logic [7:0] PRESC_RESET = 8'hE7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_we,
  input  logic [TT_DW-1:0] reg_wdata,
  output logic [TT_DW-1:0] reg_rdata,
  output logic [NUM_TIMERS-1:0] irq
);
  localparam int PW = 8;
  localparam int IW = AW - 4;

  logic          presc_we, tick;
  logic [PW-1:0] reload;
  logic [NUM_TIMERS-1:0] ctrl_we, cmp_we, cnt_we, match;
  logic [TT_DW-1:0] cnt_a [NUM_TIMERS];
  logic [TT_DW-1:0] cmp_a [NUM_TIMERS];
  logic [TT_DW-1:0] ctl_a [NUM_TIMERS];

  tt_decode #(.AW(AW), .NT(NUM_TIMERS)) u_dec (
    .we(reg_we), .addr(reg_addr), .presc_we(presc_we),
    .ctrl_we(ctrl_we), .cmp_we(cmp_we), .cnt_we(cnt_we));

  tt_prescaler #(.PW(PW), .RESET_RELOAD(PRESC_RESET)) u_presc (
    .clk(clk), .rst_n(rst_n), .reload_we(presc_we),
    .reload_wdata(reg_wdata[PW-1:0]), .reload_o(reload), .tick_o(tick));

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_ch
    tt_channel u_ch (
      .clk(clk), .rst_n(rst_n), .tick_i(tick),
      .ctrl_we(ctrl_we[g]), .cmp_we(cmp_we[g]), .cnt_we(cnt_we[g]),
      .wdata(reg_wdata), .cnt_o(cnt_a[g]), .cmp_o(cmp_a[g]),
      .ctrl_o(ctl_a[g]), .irq_o(irq[g]), .match_o(match[g]));
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0) reg_rdata = {{(TT_DW-PW){1'b0}}, reload};
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (reg_addr[AW-1:4] == IW'(i + 1)) begin
        case (reg_addr[3:0])
          SUB_CTRL: reg_rdata = ctl_a[i];
          SUB_CMP:  reg_rdata = cmp_a[i];
          SUB_CNT:  reg_rdata = cnt_a[i];
          default:  reg_rdata = '0;
        endcase
      end
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({presc_we, ctrl_we, cmp_we, cnt_we})); // R10
  AST_MATCH_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (match != '0) |-> tick); // R3
endmodule

// File: tb/tick_timer_bank_test.sv
module tick_timer_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  irq;
  int checks = 0, errors = 0;
  bit done = 0;

  tick_timer_bank uut (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always #5 clk = ~clk;

  // control word bits
  localparam logic [31:0] ENC = 32'h1, COC = 32'h2, COVF = 32'h4,
                          ENINT = 32'h100, CINT = 32'h200, INTS = 32'h400;

  function automatic logic [7:0] a_ctl(input int n); return 8'(16 * n);     endfunction
  function automatic logic [7:0] a_cmp(input int n); return 8'(16 * n + 4); endfunction
  function automatic logic [7:0] a_cnt(input int n); return 8'(16 * n + 8); endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h00, d); chk("R1 reload", d, 32'hE7);
    for (int n = 1; n <= 4; n++) begin
      rd(a_ctl(n), d); chk("R1 ctrl", d, 0);
      rd(a_cmp(n), d); chk("R1 cmp", d, 0);
      rd(a_cnt(n), d); chk("R1 cnt", d, 0);
    end
    chk("R1 irq", {28'b0, irq}, 0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(8'h0C, 32'hDEAD); wr(8'h50, 32'hBEEF); wr(8'h1C, 32'h1234);
    rd(8'h0C, d); chk("R10 hole 0x0C", d, 0);
    rd(8'h50, d); chk("R10 hole 0x50", d, 0);
    rd(8'h1C, d); chk("R10 hole 0x1C", d, 0);
    rd(8'h00, d); chk("R10 reload untouched", d, 32'hFF);
    rd(a_cnt(1), d); chk("R10 cnt untouched", d, 0);
  endtask

  // timer 1 passes its compare without clearing; R4 clear-off, R6 one event
  task automatic t_no_coc;
    logic [31:0] d;
    wr(a_cmp(1), 3);
    wr(a_ctl(1), ENC | ENINT);
    wait_n(20);
    rd(a_cnt(1), d); chk("R4 counts past compare", d, 20);
    rd(a_ctl(1), d); chk("R7 status set, R6 tally 1", d, INTS | ENINT | ENC | 32'h10);
    chk("R8 irq1 high", {31'b0, irq[0]}, 1);
    chk("R11 other irqs low", {29'b0, irq[3:1]}, 0);
  endtask

  // timer 2 with interrupt disabled
  task automatic t_enint;
    logic [31:0] d, c0;
    wr(a_cmp(2), 2);
    wr(a_ctl(2), ENC);
    wait_n(10);
    rd(a_ctl(2), d); chk("R7 status without enable, R6 no tally", d, INTS | ENC);
    chk("R8 irq2 masked", {31'b0, irq[1]}, 0);
    wr(a_ctl(2), ENINT);
    chk("R8 irq2 after enable", {31'b0, irq[1]}, 1);
    rd(a_cnt(2), c0);
    wait_n(30);
    rd(a_cnt(2), d); chk("R3 hold when disabled", d, c0);
    wr(a_ctl(2), CINT | ENINT);
    rd(a_ctl(2), d); chk("R7 clear status, bit 9 reads 0", d, ENINT);
    chk("R8 irq2 low after clear", {31'b0, irq[1]}, 0);
  endtask

  // timer 3 clear-on-compare, period 4 ticks
  task automatic t_coc;
    logic [31:0] d, a, b;
    bit bad = 0;
    wr(a_cmp(3), 3);
    wr(a_ctl(3), ENC | COC | COVF | ENINT);
    wait_n(2);
    rd(a_ctl(3), a);
    for (int k = 0; k < 8; k++) begin
      wait_n(1);
      rd(a_cnt(3), d);
      if (d > 3) bad = 1;
    end
    rd(a_ctl(3), b);
    chk("R4 counter never above compare", {31'b0, bad}, 0);
    chk("R6 tally +2 in 8 ticks", (b >> 4) & 32'hF, ((a >> 4) + 2) & 32'hF);
    chk("R8 irq3 high", {31'b0, irq[2]}, 1);
    rd(a_cnt(4), d); chk("R11 timer4 idle", d, 0);
  endtask

  // timer 4 matches every tick: tally wrap and clear priority
  task automatic t_ovf_wrap;
    logic [31:0] a, b;
    wr(a_ctl(4), ENC | COC | ENINT);
    rd(a_ctl(4), a);
    wait_n(20);
    rd(a_ctl(4), b);
    chk("R6 tally wraps", (b >> 4) & 32'hF, ((a >> 4) + 20) & 32'hF);
    wr(a_ctl(4), COC | COVF | ENINT);
    rd(a_ctl(4), b);
    chk("R6 clear wins, bit 2 reads 0", b, INTS | ENINT | COC);
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    wr(a_cmp(1), 32'hFFFF_0000);
    wr(a_ctl(1), 32'hFFFF_FFFF);
    rd(a_ctl(1), d); chk("R9 reserved bits zero", d, ENINT | COC | ENC);
  endtask

  task automatic t_cnt_write;
    logic [31:0] d;
    wr(a_cnt(1), 32'h1000);
    rd(a_cnt(1), d); chk("R5 write beats tick", d, 32'h1000);
    wait_n(1);
    rd(a_cnt(1), d); chk("R3 increments after load", d, 32'h1001);
  endtask

  task automatic t_ratio;
    logic [31:0] a, b;
    wr(8'h00, 32'hFE);
    wait_n(5);
    rd(a_cnt(1), a); wait_n(100); rd(a_cnt(1), b);
    chk("R2 divide by 2", b - a, 50);
    wr(8'h00, 32'hE7);
    rd(8'h00, a); chk("R2 reload readback", a, 32'hE7);
    wait_n(30);
    rd(a_cnt(1), a); wait_n(250); rd(a_cnt(1), b);
    chk("R2 divide by 25", b - a, 10);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1-run actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    t_reset();
    wr(8'h00, 32'hFF);
    wait_n(300);
    t_unmapped();
    t_no_coc();
    t_enint();
    t_coc();
    t_ovf_wrap();
    t_reserved();
    t_cnt_write();
    t_ratio();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule